// File: doc/BRIEF.md
# Complex-Pole First-Order Cascade Filter Engine

This block is a sample-driven IIR filter engine. Each second-order section is built from a complex first-order recursion rather than a real-coefficient biquad. This places poles and zeros more precisely and keeps round-off noise low. One input sample is taken on each sample strobe (nominally every 100 µs at 10 kHz). A sequencer then walks through the active sections one per clock. Each step reads that section's coefficients from a coefficient store and its complex state from a state store, and feeds the section's real output into the next section.

The result of the sample taken at strobe n is held back and released at strobe n+1. This gives a fixed two-period schedule. The coefficient store holds five 24-bit words for each of up to 64 sections (320 words). The state store holds two words per section (128 words). Together they stay inside a 512-word budget. The cascade has at most 64 sections, so it realizes at most 128 poles and 128 zeros.

Top module: `cfc_cascade`

## Requirements
- R1: After reset, `busy`, `overrun` and `y_valid` are 0 and `y_out` is 0. All section states are zero.
- R2: For each active section s, with input x, the complex state updates as follows. Let y = yr + j·yi, a = ar + j·ai and b = br + j·bi, with coefficients in signed Q1.22 (1.0 = 4194304). The new value is yr' = sat((ar·yr − ai·yi + br·x) >>> 22) and yi' = sat((ai·yr + ar·yi + bi·x) >>> 22).
- R3: The section output is sat(2·yr' + ((d·x) >>> 22)). It is the input of section s+1, and the output of the last active section is the sample's result.
- R4: The result of a sample accepted at strobe n is loaded into `y_out` on the clock edge of the next strobe. `y_valid` is high for exactly the one cycle after that edge. `y_out` changes on no other edge.
- R5: An accepted strobe raises `busy` on the next cycle. `busy` stays high for exactly N cycles, where N is the effective section count.
- R6: A strobe seen while `busy` is high drops its sample and leaves the state unchanged. It sets `overrun`, which stays high until `clr`.
- R7: The state words and section outputs saturate to +8388607 / −8388608 and never wrap.
- R8: `sec_count` is sampled at the accepted strobe. A value of 0 gives N = 1, values above 64 give N = 64, and any other value gives N = `sec_count`.
- R9: A coefficient write (`cw_en`) is applied only while `busy` is low. A write presented while `busy` is high is ignored. `cw_field` selects the word: 0 = ar, 1 = ai, 2 = br, 3 = bi, 4 = d. Codes 5 to 7 write nothing.
- R10: `clr` zeroes all state words and clears `overrun`. It cancels a run in progress and any unreleased result. Coefficients are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous state clear |
| smp_strobe | input | 1 | Sample strobe |
| smp_in | input | 24 | Input sample, signed |
| sec_count | input | 7 | Requested number of active sections |
| cw_en | input | 1 | Coefficient write enable |
| cw_field | input | 3 | Coefficient word select |
| cw_sec | input | 6 | Section index of the write |
| cw_data | input | 24 | Coefficient value, signed Q1.22 |
| y_out | output | 24 | Filtered output sample, signed |
| y_valid | output | 1 | One-cycle pulse when y_out is updated |
| busy | output | 1 | Cascade computation in progress |
| overrun | output | 1 | Sticky flag: a strobe was dropped |

## Verification
The assertions check these on every cycle:
- an accepted strobe raises `busy`;
- a strobe during a run sets `overrun`, and `overrun` then holds;
- `y_out` moves only at a strobe edge, and `y_valid` only follows a strobe;
- `clr` leaves the engine idle;
- no run exceeds 64 cycles.

The numerical behaviour of the complex recursions, the saturation, the chaining of sections and the dropped-sample effect are visible only through the bench's scenarios. The same holds for the clamped run lengths, the ignored writes during a run, and the state clear with kept coefficients. In those scenarios a bit-exact model predicts each released sample.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int unsigned CFC_DW    = 24;
  localparam int unsigned CFC_FRAC  = 22;
  localparam int unsigned CFC_NSEC  = 64;
  localparam int unsigned CFC_NFLD  = 5;
  localparam int unsigned CFC_FLD_W = 3;

  typedef enum logic [CFC_FLD_W-1:0] {
    FLD_AR = 3'd0,
    FLD_AI = 3'd1,
    FLD_BR = 3'd2,
    FLD_BI = 3'd3,
    FLD_D  = 3'd4
  } cfc_field_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } cfc_seq_e;
endpackage

// File: rtl/cfc_coef_store.sv
module cfc_coef_store #(
  parameter int unsigned DW   = 24,
  parameter int unsigned NSEC = 64,
  parameter int unsigned NF   = 5,
  parameter int unsigned FW   = 3,
  localparam int unsigned SW  = $clog2(NSEC)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [FW-1:0]        field,
  input  logic [SW-1:0]        wsec,
  input  logic [DW-1:0]        wdata,
  input  logic [SW-1:0]        rsec,
  output logic [NF-1:0][DW-1:0] rd
);
  for (genvar f = 0; f < NF; f++) begin : g_fld
    logic [DW-1:0] mem [NSEC];
    logic          fld_we;
    assign fld_we = we && (field == FW'(f));
    always_ff @(posedge clk) begin
      if (fld_we) mem[wsec] <= wdata;
    end
    assign rd[f] = mem[rsec];
  end
endmodule

// File: rtl/cfc_state_store.sv
module cfc_state_store #(
  parameter int unsigned DW   = 24,
  parameter int unsigned NSEC = 64,
  localparam int unsigned SW  = $clog2(NSEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [SW-1:0] sec,
  input  logic [DW-1:0] wyr,
  input  logic [DW-1:0] wyi,
  output logic [DW-1:0] ryr,
  output logic [DW-1:0] ryi
);
  logic [DW-1:0] st_re [NSEC];
  logic [DW-1:0] st_im [NSEC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEC; i++) begin
        st_re[i] <= '0;
        st_im[i] <= '0;
      end
    end else if (clr) begin
      for (int i = 0; i < NSEC; i++) begin
        st_re[i] <= '0;
        st_im[i] <= '0;
      end
    end else if (we) begin
      st_re[sec] <= wyr;
      st_im[sec] <= wyi;
    end
  end

  assign ryr = st_re[sec];
  assign ryi = st_im[sec];
endmodule

// File: rtl/cfc_section_dp.sv
module cfc_section_dp #(
  parameter int unsigned DW   = 24,
  parameter int unsigned FRAC = 22,
  localparam int unsigned AW  = 2 * DW
) (
  input  logic signed [DW-1:0] x,
  input  logic signed [DW-1:0] yr,
  input  logic signed [DW-1:0] yi,
  input  logic signed [DW-1:0] ar,
  input  logic signed [DW-1:0] ai,
  input  logic signed [DW-1:0] br,
  input  logic signed [DW-1:0] bi,
  input  logic signed [DW-1:0] d,
  output logic signed [DW-1:0] yr_n,
  output logic signed [DW-1:0] yi_n,
  output logic signed [DW-1:0] y_o
);
  localparam logic signed [AW-1:0] HI = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] LO = ~HI;

  function automatic logic signed [DW-1:0] sat(input logic signed [AW-1:0] v);
    if (v > HI)      sat = HI[DW-1:0];
    else if (v < LO) sat = LO[DW-1:0];
    else             sat = v[DW-1:0];
  endfunction

  logic signed [AW-1:0] acc_re, acc_im, prod_d, out_sum, yr_w;

  always_comb begin
    // four real products for a*y, two for b*x (x is real)
    acc_re  = (ar * yr) - (ai * yi) + (br * x);
    acc_im  = (ai * yr) + (ar * yi) + (bi * x);
    yr_n    = sat(acc_re >>> FRAC);
    yi_n    = sat(acc_im >>> FRAC);
    prod_d  = d * x;
    yr_w    = {{(AW-DW){yr_n[DW-1]}}, yr_n};
    out_sum = (yr_w <<< 1) + (prod_d >>> FRAC);
    y_o     = sat(out_sum);
  end
endmodule

// File: rtl/cfc_seq.sv
module cfc_seq #(
  parameter int unsigned NSEC = 64,
  localparam int unsigned SW  = $clog2(NSEC),
  localparam int unsigned CW  = SW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          strobe,
  input  logic [CW-1:0] sec_count,
  output logic          busy,
  output logic          overrun,
  output logic          accept,
  output logic          step,
  output logic          last,
  output logic [SW-1:0] sec
);
  import cfc_pkg::*;

  cfc_seq_e      st_q, st_d;
  logic [SW-1:0] sec_d, lim_q, lim_d, lim_req;
  logic          ovr_d;

  // R8: clamp the requested count into 1..NSEC (stored as count-1)
  always_comb begin
    if (sec_count == '0)               lim_req = '0;
    else if (sec_count > CW'(NSEC))    lim_req = SW'(NSEC - 1);
    else                               lim_req = SW'(sec_count - CW'(1));
  end

  assign busy   = (st_q == SEQ_RUN);
  assign accept = strobe && !busy && !clr;
  assign step   = busy && !clr;
  assign last   = (sec == lim_q);

  always_comb begin
    st_d  = st_q;
    sec_d = sec;
    lim_d = lim_q;
    ovr_d = overrun;
    if (clr) begin
      st_d  = SEQ_IDLE;
      ovr_d = 1'b0;
    end else if (accept) begin
      st_d  = SEQ_RUN;
      sec_d = '0;
      lim_d = lim_req;
    end else if (step) begin
      sec_d = sec + SW'(1);
      if (last) st_d = SEQ_IDLE;
      if (strobe) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SEQ_IDLE;
      sec     <= '0;
      lim_q   <= '0;
      overrun <= 1'b0;
    end else begin
      st_q    <= st_d;
      sec     <= sec_d;
      lim_q   <= lim_d;
      overrun <= ovr_d;
    end
  end
endmodule

// File: rtl/cfc_cascade.sv
module cfc_cascade #(
  parameter int unsigned DW   = cfc_pkg::CFC_DW,
  parameter int unsigned FRAC = cfc_pkg::CFC_FRAC,
  parameter int unsigned NSEC = cfc_pkg::CFC_NSEC,
  localparam int unsigned SW  = $clog2(NSEC),
  localparam int unsigned CW  = SW + 1,
  localparam int unsigned NF  = cfc_pkg::CFC_NFLD,
  localparam int unsigned FW  = cfc_pkg::CFC_FLD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          smp_strobe,
  input  logic [DW-1:0] smp_in,
  input  logic [CW-1:0] sec_count,
  input  logic          cw_en,
  input  logic [FW-1:0] cw_field,
  input  logic [SW-1:0] cw_sec,
  input  logic [DW-1:0] cw_data,
  output logic [DW-1:0] y_out,
  output logic          y_valid,
  output logic          busy,
  output logic          overrun
);
  import cfc_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic          accept, step, last;
  logic [SW-1:0] sec;

  cfc_seq #(.NSEC(NSEC)) u_seq (
    .clk(clk), .rst_n(rs_n), .clr(clr), .strobe(smp_strobe),
    .sec_count(sec_count), .busy(busy), .overrun(overrun),
    .accept(accept), .step(step), .last(last), .sec(sec)
  );

  logic [NF-1:0][DW-1:0] cf;
  logic                  cw_we;
  assign cw_we = cw_en && !busy;   // R9

  cfc_coef_store #(.DW(DW), .NSEC(NSEC), .NF(NF), .FW(FW)) u_coef (
    .clk(clk), .we(cw_we), .field(cw_field), .wsec(cw_sec),
    .wdata(cw_data), .rsec(sec), .rd(cf)
  );

  logic [DW-1:0] st_re, st_im, nx_re, nx_im, sec_y;

  cfc_state_store #(.DW(DW), .NSEC(NSEC)) u_state (
    .clk(clk), .rst_n(rs_n), .clr(clr), .we(step), .sec(sec),
    .wyr(nx_re), .wyi(nx_im), .ryr(st_re), .ryi(st_im)
  );

  logic [DW-1:0] x_q, x_d;

  cfc_section_dp #(.DW(DW), .FRAC(FRAC)) u_dp (
    .x(x_q), .yr(st_re), .yi(st_im),
    .ar(cf[FLD_AR]), .ai(cf[FLD_AI]), .br(cf[FLD_BR]), .bi(cf[FLD_BI]),
    .d(cf[FLD_D]), .yr_n(nx_re), .yi_n(nx_im), .y_o(sec_y)
  );

  logic [DW-1:0] res_q, res_d, yo_d;
  logic          pend_q, pend_d, vld_d;

  always_comb begin
    x_d    = x_q;
    res_d  = res_q;
    pend_d = pend_q;
    yo_d   = y_out;
    vld_d  = 1'b0;
    if (accept)    x_d = smp_in;
    else if (step) x_d = sec_y;
    if (clr) begin
      pend_d = 1'b0;
    end else if (step && last) begin
      res_d  = sec_y;
      pend_d = 1'b1;
    end else if (smp_strobe && pend_q) begin
      yo_d   = res_q;   // R4: release on the following strobe
      vld_d  = 1'b1;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      x_q     <= '0;
      res_q   <= '0;
      pend_q  <= 1'b0;
      y_out   <= '0;
      y_valid <= 1'b0;
    end else begin
      x_q     <= x_d;
      res_q   <= res_d;
      pend_q  <= pend_d;
      y_out   <= yo_d;
      y_valid <= vld_d;
    end
  end
endmodule

// File: rtl/cfc_cascade_chk.sv
module cfc_cascade_chk #(
  parameter int unsigned NSEC = 64,
  parameter int unsigned DW   = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          smp_strobe,
  input logic [DW-1:0] y_out,
  input logic          y_valid,
  input logic          busy,
  input logic          overrun
);
  logic [$clog2(NSEC+2)-1:0] run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  a_r5_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_strobe && !busy && !clr) |=> busy);
  a_r6_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_strobe && busy && !clr) |=> overrun);
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr) |=> overrun);
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_strobe |=> $stable(y_out));
  a_r4_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> $past(smp_strobe));
  a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy && !overrun));
  a_r8_run_len: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= ($clog2(NSEC+2))'(NSEC));
endmodule

bind cfc_cascade cfc_cascade_chk #(.NSEC(NSEC), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .smp_strobe(smp_strobe),
  .y_out(y_out), .y_valid(y_valid), .busy(busy), .overrun(overrun)
);

// File: tb/sim_cfc_cascade.sv
module sim_cfc_cascade;
  localparam longint ONE = 4194304;
  localparam longint MAXV = 8388607;
  localparam longint MINV = -8388608;

  logic clk, rst_n, clr, smp_strobe, cw_en;
  logic [23:0] smp_in, cw_data, y_out;
  logic [6:0]  sec_count;
  logic [2:0]  cw_field;
  logic [5:0]  cw_sec;
  logic y_valid, busy, overrun;

  cfc_cascade u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0, bad = 0;
  string tag = "R2 R3";
  longint mc [5][64];
  longint syr [64], syi [64];
  longint exp_q [$];
  int eff;

  function automatic longint sat(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  function automatic longint model(longint xin);
    longint x = xin;
    for (int s = 0; s < eff; s++) begin
      longint pr = mc[0][s]*syr[s] - mc[1][s]*syi[s] + mc[2][s]*x;
      longint pi = mc[1][s]*syr[s] + mc[0][s]*syi[s] + mc[3][s]*x;
      longint yr = sat(pr >>> 22);
      longint yi = sat(pi >>> 22);
      longint o  = sat(2*yr + ((mc[4][s]*x) >>> 22));
      syr[s] = yr; syi[s] = yi; x = o;
    end
    return x;
  endfunction

  task automatic check(string req, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pop expected results as the design releases them
  always @(negedge clk) begin
    if (rst_n && y_valid) begin
      if (exp_q.size() == 0) check({tag, " unexpected release"}, 1, 0);
      else check(tag, longint'($signed(y_out)), exp_q.pop_front());
    end
  end

  task automatic wr(int f, int s, longint v, bit apply);
    @(negedge clk);
    cw_en = 1; cw_field = 3'(f); cw_sec = 6'(s); cw_data = 24'(v);
    if (apply) mc[f][s] = v;
    @(negedge clk);
    cw_en = 0;
  endtask

  function automatic int clampc(int c);
    if (c == 0) return 1;
    if (c > 64) return 64;
    return c;
  endfunction

  int blen, vld_first;
  // driver: strobe one sample, push its expected result, wait for the run
  task automatic send(longint x);
    @(negedge clk);
    smp_in = 24'(x); smp_strobe = 1;
    eff = clampc(int'(sec_count));
    exp_q.push_back(model(x));
    @(negedge clk);
    smp_strobe = 0;
    vld_first = y_valid;
    blen = 0;
    while (busy) begin blen++; @(negedge clk); end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; clr = 0; smp_strobe = 0; smp_in = 0; sec_count = 7'd3;
    cw_en = 0; cw_field = 0; cw_sec = 0; cw_data = 0;
    for (int s = 0; s < 64; s++) begin syr[s] = 0; syi[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 overrun", overrun, 0);
    check("R1 y_valid", y_valid, 0);
    check("R1 y_out", y_out, 0);

    for (int s = 0; s < 64; s++) begin
      wr(0, s, ONE/2 + s*1000, 1);
      wr(1, s, ONE/4 - s*500, 1);
      wr(2, s, ONE/2, 1);
      wr(3, s, s*300 - 5000, 1);
      wr(4, s, ONE/4, 1);
    end
    wr(6, 0, 12345, 0);  // R9: field code 6 writes nothing

    // R2 R3: three sections, impulse then varied samples
    sec_count = 7'd3;
    send(1000000);
    check("R4 no release on first strobe", vld_first, 0);
    check("R5 busy length", blen, 3);
    send(0);
    check("R4 release on next strobe", vld_first, 1);
    check("R4 valid one cycle", y_valid, 0);
    send(-2500000); send(777); send(4000000); send(-1);

    // R6: strobe during a run is dropped
    @(negedge clk); smp_in = 24'(1000000); smp_strobe = 1;
    eff = 3; exp_q.push_back(model(1000000));
    @(negedge clk); smp_strobe = 0;
    @(negedge clk); smp_in = 24'(-3000000); smp_strobe = 1;
    @(negedge clk); smp_strobe = 0;
    check("R6 overrun set", overrun, 1);
    while (busy) @(negedge clk);
    tag = "R6 dropped sample";
    send(200000); send(0);
    check("R6 overrun sticky", overrun, 1);

    // R9: write during a run ignored
    tag = "R9 write while busy";
    @(negedge clk); smp_in = 24'(50000); smp_strobe = 1;
    exp_q.push_back(model(50000));
    @(negedge clk); smp_strobe = 0; cw_en = 1; cw_field = 3'd2; cw_sec = 0; cw_data = 24'(ONE);
    @(negedge clk); cw_en = 0;
    while (busy) @(negedge clk);
    send(300000); send(-300000);

    // R8: count clamping
    tag = "R8 clamp";
    sec_count = 7'd0;  send(123456);
    check("R8 count 0 gives one section", blen, 1);
    sec_count = 7'd100; send(-654321);
    check("R8 count 100 gives 64", blen, 64);
    send(10); send(0);

    // R10: clear keeps coefficients, zeroes state
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    exp_q.delete();
    for (int s = 0; s < 64; s++) begin syr[s] = 0; syi[s] = 0; end
    check("R10 overrun cleared", overrun, 0);
    tag = "R10 after clear";
    sec_count = 7'd2;
    send(900000);
    check("R10 pending cancelled", vld_first, 0);
    send(0); send(0);

    // R7: saturation
    tag = "R7 saturation";
    sec_count = 7'd1;
    wr(0, 0, 0, 1); wr(1, 0, 0, 1); wr(2, 0, ONE, 1); wr(3, 0, 0, 1); wr(4, 0, ONE, 1);
    send(8000000);
    send(-8000000);
    check("R7 positive clip", longint'($signed(y_out)), MAXV);
    send(0);
    check("R7 negative clip", longint'($signed(y_out)), MINV);
    send(0);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule